// File: doc/BRIEF.md
# Premultiplied Alpha Row Blender

This block composites one plane's row of pixels onto a destination row held in an external single-port-style line memory. Each pixel carries four 16-bit channels (alpha, red, green, blue). Source colors arrive already scaled by their own alpha, so each destination channel becomes the source channel plus the old destination channel weighted by the source transparency. Every result is rounded to the nearest integer. The background under the row is taken as fully opaque, so every pixel written back carries an opaque alpha.

A row begins with a one-cycle `row_start` pulse that supplies the plane's left column and its width. Source pixels then stream in, one per clock when `src_valid` is high. The n-th accepted pixel of the row goes to column left+n. For each such pixel the block issues a read of that column, combines the returned value, and writes the result back three cycles after acceptance. Pixels past the plane width, past the row length, or beyond the last column of the row are discarded without touching memory.

Top module: `pm_row_blend`

## Requirements
- R1: Each color channel written is the low 16 bits of (S·65535 + D·(65535 − Sa) + 32767) / 65535, with integer division. S is the source channel, D is the destination channel read back, and Sa is the source alpha.
- R2: The source color is not scaled by alpha again: when the source alpha is 0xFFFF, the written colors equal the source colors whatever the destination holds.
- R3: The pixel layout is alpha in bits 63:48, red in 47:32, green in 31:16 and blue in 15:0. Every written pixel has alpha 0xFFFF whatever the source or destination alpha.
- R4: After `row_start`, the k-th source pixel of the row (counting from 0) targets column `row_x1` + k.
- R5: Only the first min(`row_width`, ROW_LEN) source pixels of a row are blended. Any further pixels are ignored, and a width of 0 touches no column.
- R6: A pixel whose target column is at or beyond ROW_LEN is dropped, with no read and no write.
- R7: `rd_en` and `rd_addr` are driven combinationally in the cycle a pixel is accepted. `rd_data` is taken in the next cycle. The matching `wr_en` pulse appears three clock edges after acceptance. One pixel per clock is sustained.
- R8: A source pixel presented in the same cycle as `row_start` is ignored and does not count toward the new row.
- R9: During and right after reset, `rd_en` and `wr_en` are low, and no pixel is accepted until a `row_start` has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start | input | 1 | Begins a new row and loads the left column and width |
| row_x1 | input | COL_W | Destination column of the plane's first pixel |
| row_width | input | CNT_W | Plane width in pixels |
| src_valid | input | 1 | Source pixel present this cycle |
| src_pix | input | 64 | Source pixel, premultiplied ARGB |
| rd_en | output | 1 | Destination read request |
| rd_addr | output | COL_W | Destination column to read |
| rd_data | input | 48 | Destination colors (R,G,B) returned one cycle after `rd_en` |
| wr_en | output | 1 | Write of a blended pixel |
| wr_addr | output | COL_W | Destination column written |
| wr_data | output | 64 | Blended pixel, alpha forced opaque |

## Verification
The assertions take for granted two things about the environment. The line memory answers a read on the very next clock edge. No new row is started while writes of the previous row are still in flight, since a read could otherwise see a column before its pending write lands. The bench models the memory with a one-cycle registered read, and after each row it idles long enough for the pipeline to drain before the next `row_start`. Random source colors are kept no larger than their alpha, as premultiplied data should be. This keeps results within 16 bits, and one directed case deliberately mixes in stale destination data to exercise rounding.

// File: rtl/pm_row_blend.sv
module pm_row_blend #(
  parameter int ROW_LEN = 64,
  parameter int CNT_W   = 16,
  parameter int CH_W    = 16,
  localparam int COL_W  = $clog2(ROW_LEN),
  localparam int PIX_W  = 4 * CH_W,
  localparam int RGB_W  = 3 * CH_W,
  localparam int SUM_W  = 2 * CH_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic [COL_W-1:0] row_x1,
  input  logic [CNT_W-1:0] row_width,
  input  logic             src_valid,
  input  logic [PIX_W-1:0] src_pix,
  output logic             rd_en,
  output logic [COL_W-1:0] rd_addr,
  input  logic [RGB_W-1:0] rd_data,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_addr,
  output logic [PIX_W-1:0] wr_data
);

  localparam logic [SUM_W-1:0] ONES_W = SUM_W'({CH_W{1'b1}});
  localparam logic [SUM_W-1:0] HALF_W = ONES_W >> 1;
  localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(ROW_LEN);

  logic [COL_W-1:0] base_q;
  logic [CNT_W-1:0] lim_q, idx_q;
  logic             s1_v, s2_v;
  logic [COL_W-1:0] s1_addr, s2_addr;
  logic [PIX_W-1:0] s1_pix;

  wire [CNT_W:0] col_full = {{(CNT_W + 1 - COL_W){1'b0}}, base_q} + {1'b0, idx_q};
  wire           in_span  = idx_q < lim_q;
  wire           in_row   = col_full < (CNT_W + 1)'(ROW_LEN);
  wire           live     = src_valid && !row_start;

  assign rd_en   = live && in_span && in_row;
  assign rd_addr = col_full[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      idx_q  <= '0;
    end else if (row_start) begin
      base_q <= row_x1;
      lim_q  <= (row_width < LEN_C) ? row_width : LEN_C;
      idx_q  <= '0;
    end else if (live && in_span) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      wr_en   <= 1'b0;
      s1_addr <= '0;
      s2_addr <= '0;
      wr_addr <= '0;
      s1_pix  <= '0;
    end else begin
      s1_v    <= rd_en;
      s1_addr <= rd_addr;
      s1_pix  <= src_pix;
      s2_v    <= s1_v;
      s2_addr <= s1_addr;
      wr_en   <= s2_v;
      wr_addr <= s2_addr;
    end
  end

  wire [SUM_W-1:0] inv_a = ONES_W - SUM_W'(s1_pix[3*CH_W +: CH_W]);

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [SUM_W-1:0] num_q;
    logic [CH_W-1:0]  res_q;
    wire  [SUM_W-1:0] src_w = SUM_W'(s1_pix[c*CH_W +: CH_W]);
    wire  [SUM_W-1:0] dst_w = SUM_W'(rd_data[c*CH_W +: CH_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        num_q <= '0;
        res_q <= '0;
      end else begin
        num_q <= src_w * ONES_W + dst_w * inv_a + HALF_W;
        res_q <= CH_W'(num_q / ONES_W);
      end
    end
  end

  assign wr_data = {{CH_W{1'b1}}, g_ch[2].res_q, g_ch[1].res_q, g_ch[0].res_q};

endmodule

// File: rtl/pm_row_blend_chk.sv
module pm_row_blend_chk #(
  parameter int ROW_LEN = 64,
  parameter int CNT_W   = 16,
  parameter int CH_W    = 16,
  localparam int COL_W  = $clog2(ROW_LEN),
  localparam int PIX_W  = 4 * CH_W,
  localparam int RGB_W  = 3 * CH_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_start,
  input logic [COL_W-1:0] row_x1,
  input logic [CNT_W-1:0] row_width,
  input logic             src_valid,
  input logic [PIX_W-1:0] src_pix,
  input logic             rd_en,
  input logic [COL_W-1:0] rd_addr,
  input logic [RGB_W-1:0] rd_data,
  input logic             wr_en,
  input logic [COL_W-1:0] wr_addr,
  input logic [PIX_W-1:0] wr_data
);

  p_alpha_opaque_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[PIX_W-1 -: CH_W] == {CH_W{1'b1}});

  p_write_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(rd_en, 3) && wr_addr == $past(rd_addr, 3)));

  p_read_follows_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ##2 (wr_en && wr_addr == $past(rd_addr, 3)));

  p_no_read_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (src_valid && !row_start));

  p_opaque_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(src_pix[PIX_W-1 -: CH_W], 3) == {CH_W{1'b1}})
      |-> wr_data[RGB_W-1:0] == $past(src_pix[RGB_W-1:0], 3));

  p_no_reuse_in_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && !$past(row_start)) |-> rd_addr != $past(rd_addr));

endmodule

bind pm_row_blend pm_row_blend_chk #(.ROW_LEN(ROW_LEN), .CNT_W(CNT_W), .CH_W(CH_W)) chk_i (.*);

// File: tb/pm_row_blend_tb.sv
module pm_row_blend_tb_top;
  localparam int ROW_LEN = 64;
  localparam int COL_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_start = 1'b0;
  logic [5:0]  row_x1 = '0;
  logic [15:0] row_width = '0;
  logic        src_valid = 1'b0;
  logic [63:0] src_pix = '0;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [47:0] rd_data;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [63:0] wr_data;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [63:0] mem  [ROW_LEN];
  logic [63:0] gold [ROW_LEN];
  logic [63:0] src_buf [128];
  logic        ld_en = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;

  always #2.5 clk = ~clk;

  pm_row_blend dut_i (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_x1(row_x1),
    .row_width(row_width), .src_valid(src_valid), .src_pix(src_pix),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else begin
      if (rd_en) rd_data <= mem[rd_addr][47:0];
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] ch(input logic [15:0] s, input logic [15:0] d,
                                     input logic [15:0] a);
    logic [33:0] n;
    n = {18'b0, s} * 34'd65535 + {18'b0, d} * (34'd65535 - {18'b0, a}) + 34'd32767;
    ch = 16'(n / 34'd65535);
  endfunction

  function automatic logic [63:0] px(input logic [63:0] s, input logic [63:0] d);
    px = {16'hFFFF, ch(s[47:32], d[47:32], s[63:48]),
          ch(s[31:16], d[31:16], s[63:48]), ch(s[15:0], d[15:0], s[63:48])};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [63:0] v, input bit rnd);
    for (int i = 0; i < ROW_LEN; i++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_addr = 6'(i);
      ld_data = rnd ? {$urandom, $urandom} : v;
      gold[i] = ld_data;
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_row(input int x1, input int w, input int n, input bit overlap,
                         input string tag);
    int lim;
    @(negedge clk);
    row_start = 1'b1;
    row_x1 = 6'(x1);
    row_width = 16'(w);
    src_valid = overlap;
    src_pix = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    row_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      src_valid = 1'b1;
      src_pix = src_buf[i];
      @(negedge clk);
    end
    src_valid = 1'b0;
    repeat (6) @(negedge clk);
    lim = (w < ROW_LEN) ? w : ROW_LEN;
    for (int i = 0; i < n && i < lim; i++)
      if (x1 + i < ROW_LEN) gold[x1 + i] = px(src_buf[i], gold[x1 + i]);
    for (int c = 0; c < ROW_LEN; c++)
      check(mem[c] === gold[c], $sformatf("%s col %0d", tag, c), mem[c], gold[c]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(rd_en === 1'b0 && wr_en === 1'b0, "R9 reset outputs", {62'b0, rd_en, wr_en}, 64'h0);
    src_valid = 1'b1;
    #1;
    check(rd_en === 1'b0, "R9 no read before row", {63'b0, rd_en}, 64'h0);
    src_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    src_valid = 1'b1;
    #1;
    check(rd_en === 1'b0, "R9 no read before row_start", {63'b0, rd_en}, 64'h0);
    src_valid = 1'b0;

    preload(64'h0, 1'b1);

    // R7 latency of a single pixel
    @(negedge clk);
    row_start = 1'b1; row_x1 = 6'd5; row_width = 16'd1;
    @(negedge clk);
    row_start = 1'b0; src_valid = 1'b1; src_pix = 64'hFFFF_1111_2222_3333;
    #1;
    check(rd_en === 1'b1 && rd_addr === 6'd5, "R7 read issued", {57'b0, rd_en, rd_addr}, 64'h45);
    @(negedge clk);
    src_valid = 1'b0;
    @(negedge clk);
    check(wr_en === 1'b0, "R7 no write after two edges", {63'b0, wr_en}, 64'h0);
    @(negedge clk);
    check(wr_en === 1'b1 && wr_addr === 6'd5, "R7 write after three edges",
          {57'b0, wr_en, wr_addr}, 64'h45);
    check(wr_data === 64'hFFFF_1111_2222_3333, "R2 opaque source copied", wr_data,
          64'hFFFF_1111_2222_3333);
    repeat (3) @(negedge clk);
    gold[5] = 64'hFFFF_1111_2222_3333;

    // R2 full alpha over random destination
    for (int i = 0; i < 8; i++) src_buf[i] = {16'hFFFF, $urandom, 16'(i * 4097)};
    run_row(0, 8, 8, 1'b0, "R2 opaque row");

    // R3 fully transparent source keeps colors, forces alpha
    preload(64'h0, 1'b1);
    for (int i = 0; i < 8; i++) src_buf[i] = 64'h0;
    run_row(20, 8, 8, 1'b0, "R3 transparent row");

    // R1 rounding on half alpha
    preload(64'h1234_0001_7FFF_FFFF, 1'b0);
    for (int i = 0; i < 4; i++) src_buf[i] = {16'h8000, 16'h0, 16'h0001, 16'(i)};
    run_row(10, 4, 4, 1'b0, "R1 rounding");

    // R5 zero width touches nothing
    for (int i = 0; i < 4; i++) src_buf[i] = 64'hFFFF_AAAA_BBBB_CCCC;
    run_row(3, 0, 4, 1'b0, "R5 zero width");

    // R5 extra pixels past width ignored
    run_row(30, 5, 9, 1'b0, "R5 past width");

    // R5 width beyond the row length
    preload(64'h0, 1'b1);
    for (int i = 0; i < 70; i++) src_buf[i] = {16'hC000, 16'(i), 16'(i * 3), 16'(i * 7)};
    run_row(0, 200, 70, 1'b0, "R5 wide plane");

    // R6 columns past the row end dropped
    for (int i = 0; i < 10; i++) src_buf[i] = {16'hFFFF, 16'(i), 16'h5555, 16'h6666};
    run_row(60, 10, 10, 1'b0, "R6 right clip");

    // R8 pixel beside row_start ignored
    for (int i = 0; i < 3; i++) src_buf[i] = {16'hFFFF, 16'h0F0F, 16'(i), 16'hF0F0};
    run_row(40, 3, 3, 1'b1, "R8 overlap");

    // R4 random rows at random positions
    for (int r = 0; r < 20; r++) begin
      int x1;
      int w;
      int n;
      x1 = int'($urandom % ROW_LEN);
      w = int'($urandom % 80);
      n = int'($urandom % 100);
      for (int i = 0; i < n; i++) begin
        logic [15:0] a;
        a = 16'($urandom);
        src_buf[i] = {a, 16'($urandom % ({16'b0, a} + 1)), 16'($urandom % ({16'b0, a} + 1)),
                      16'($urandom % ({16'b0, a} + 1))};
      end
      run_row(x1, w, n, 1'b0, "R4 random row");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule